// File: doc/BRIEF.md
# Command Word Packet Framer

The framer sits between a 32-bit command word source and a drawing engine. Words enter through a valid/ready port. The framer reads the opcode in the top byte of each packet's first word and works out how long the packet is. Most opcodes have a fixed length taken from a per-opcode count. Two families of line-strip opcodes have no fixed length: they run until a terminator vertex word appears. Every accepted word is written into a circular local buffer. When the last word of a packet arrives, the framer raises a one-cycle packet strobe with the opcode, the word count and the buffer index of the first word. The engine then reads the words back through a read port.

Eight single-word opcodes load a bank of eight environment registers. These packets are still framed and reported like any other packet. A 13-bit status field is built from two of the registers. A line strip that does not fit in the buffer is dropped. The framer then discards the rest of that strip and raises a one-cycle drop flag.

Top module: `packet_framer`

## Requirements
- R1: After reset, `wordReady` is 1 and `pktValid`/`pktDrop` are 0. Environment register i (0..7) holds `{8'hE0 + i, 24'h0}`, so `statusLow` reads 0.
- R2: The packet length is 1 plus an extra count set by the opcode (the top byte of word 0). The counts are:
  - 11 for 0x3C–0x3F.
  - 8 for 0x2C–0x2F and 0x34–0x37.
  - 7 for 0x38–0x3B.
  - 6 for 0x24–0x27.
  - 5 for 0x30–0x33.
  - 4 for 0x28–0x2B.
  - 3 for 0x20–0x23, 0x50–0x57 and 0x64–0x67.
  - 2 for 0x02, 0x40–0x47, 0x60–0x63, 0x74–0x77 and 0x7C–0x7F.
  - 1 for 0x68–0x6B, 0x70–0x73 and 0x78–0x7B.
  - 0 for every other opcode not covered by R3–R5.
  
  The contents of the later words never change a fixed length.
- R3: Opcodes 0x80–0x9F form 4-word packets. Opcodes 0xA0–0xDF form 3-word packets.
- R4: For opcodes 0x48–0x4F, the word at index k ≥ 3 ends the packet when `(word & 32'hF000F000) == 32'h50005000`. Each index is tested in turn. The terminator is part of the packet, so the length is k+1.
- R5: For opcodes 0x58–0x5F, the same terminator test applies only at even indices k ≥ 4. The length is k+1. A match at an odd index or below index 4 does not end the packet.
- R6: While a packet is incomplete, `pktValid` stays 0 however long the input pauses. Framing resumes with the next word.
- R7: Stored words go to consecutive buffer indices modulo DEPTH (a power of two). `pktStart` is the index of word 0. `rdData` returns the buffer word at `rdAddr`.
- R8: A packet with opcode 0xE0–0xE7 is one word long. It stores the whole word into environment register `opcode & 7`, which is readable on `envData` when `envSel` selects it.
- R9: `statusLow[10:0]` equals environment register 1 bits 10:0. `statusLow[12:11]` equals environment register 6 bits 1:0.
- R10: If a line strip reaches DEPTH words without a terminator, `pktDrop` pulses once and no `pktValid` is raised. Later words are discarded and not stored, up to and including the next terminator at a valid index position (R4/R5). Framing then restarts.
- R11: `pktValid` is high for exactly the cycle after the packet's last word is accepted, once per packet. `pktLen` lies in 1..DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordIn | input | 32 | Command word |
| wordValid | input | 1 | Command word present |
| wordReady | output | 1 | Framer accepts a word |
| pktValid | output | 1 | One-cycle complete-packet strobe |
| pktOpcode | output | 8 | Opcode of the reported packet |
| pktLen | output | $clog2(DEPTH+1) | Word count of the reported packet |
| pktStart | output | $clog2(DEPTH) | Buffer index of word 0 |
| pktDrop | output | 1 | One-cycle overflow drop strobe |
| rdAddr | input | $clog2(DEPTH) | Buffer read index |
| rdData | output | 32 | Buffer word at rdAddr |
| envSel | input | 3 | Environment register select |
| envData | output | 32 | Selected environment register |
| statusLow | output | 13 | Status field built from the environment registers |

## Verification
The bench builds the framer with DEPTH = 16 rather than the default 32. At that depth, a line strip of only sixteen words overflows the buffer. Both strip families can then be driven into the drop and discard path cheaply, including a terminator that falls at an odd index while words are being discarded. The smaller depth also makes the buffer index wrap within a few dozen packets, so start indices are checked across the wrap point. The largest fixed packet (twelve words) still fits.

// File: rtl/framer_pkg.sv
package framer_pkg;

  localparam int ENV_COUNT = 8;
  localparam logic [31:0] TERM_MASK = 32'hF000_F000;
  localparam logic [31:0] TERM_MATCH = 32'h5000_5000;

  typedef enum logic [1:0] {
    LEN_FIXED,
    LEN_STRIP_SINGLE,
    LEN_STRIP_PAIR
  } lenKind_t;

  typedef struct packed {
    logic storeWord;
    logic markStart;
    logic emitPkt;
    logic dropPkt;
    logic envWrite;
  } ctrlStrobe_t;

  function automatic lenKind_t lenKindOf(input logic [7:0] op);
    if (op[7:3] == 5'b01001) return LEN_STRIP_SINGLE;
    if (op[7:3] == 5'b01011) return LEN_STRIP_PAIR;
    return LEN_FIXED;
  endfunction

  // Extra words after word 0 for fixed-length opcodes.
  function automatic logic [3:0] extraWords(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    unique case (op[7:5])
      3'd0: n = (op == 8'h02) ? 4'd2 : 4'd0;
      3'd1: begin
        unique case (op[4:2])
          3'd0: n = 4'd3;
          3'd1: n = 4'd6;
          3'd2: n = 4'd4;
          3'd3: n = 4'd8;
          3'd4: n = 4'd5;
          3'd5: n = 4'd8;
          3'd6: n = 4'd7;
          default: n = 4'd11;
        endcase
      end
      3'd2: n = op[4] ? 4'd3 : 4'd2;
      3'd3: begin
        unique case (op[4:2])
          3'd0: n = 4'd2;
          3'd1: n = 4'd3;
          3'd2: n = 4'd1;
          3'd3: n = 4'd0;
          3'd4: n = 4'd1;
          3'd5: n = 4'd2;
          3'd6: n = 4'd1;
          default: n = 4'd2;
        endcase
      end
      3'd4: n = 4'd3;
      3'd5, 3'd6: n = 4'd2;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic isTerminator(input logic [31:0] w);
    return (w & TERM_MASK) == TERM_MATCH;
  endfunction

endpackage

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW = 6,
  parameter int LW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inFire,
  input  logic [31:0]       wordIn,
  output ctrlStrobe_t       strobe,
  output logic [LW-1:0]     emitLen,
  output logic [7:0]        emitOp
);

  typedef enum logic [1:0] {ST_IDLE, ST_COLLECT, ST_DISCARD} state_t;

  state_t        stateQ, stateD;
  logic [CW-1:0] idxQ, idxD;
  logic [3:0]    lastQ, lastD;
  lenKind_t      kindQ, kindD;
  logic [7:0]    opQ, opD;

  logic [7:0] hdrOp;
  logic [3:0] hdrExtra;
  lenKind_t   hdrKind;
  logic       termWord;
  logic       stripHit;

  assign hdrOp    = wordIn[31:24];
  assign hdrExtra = extraWords(hdrOp);
  assign hdrKind  = lenKindOf(hdrOp);
  assign termWord = isTerminator(wordIn);

  always_comb begin
    strobe   = '0;
    stateD   = stateQ;
    idxD     = idxQ;
    lastD    = lastQ;
    kindD    = kindQ;
    opD      = opQ;
    emitLen  = LW'(idxQ) + LW'(1);
    emitOp   = opQ;
    stripHit = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        emitLen = LW'(1);
        emitOp  = hdrOp;
        if (inFire) begin
          strobe.storeWord = 1'b1;
          strobe.markStart = 1'b1;
          strobe.envWrite  = (hdrOp[7:3] == 5'b11100);
          if (hdrKind == LEN_FIXED && hdrExtra == 4'd0) begin
            strobe.emitPkt = 1'b1;
          end else begin
            stateD = ST_COLLECT;
            idxD   = CW'(1);
            lastD  = hdrExtra;
            kindD  = hdrKind;
            opD    = hdrOp;
          end
        end
      end
      ST_COLLECT: begin
        if (inFire) begin
          strobe.storeWord = 1'b1;
          idxD = idxQ + CW'(1);
          if (kindQ == LEN_FIXED) begin
            if (idxQ == CW'(lastQ)) begin
              strobe.emitPkt = 1'b1;
              stateD = ST_IDLE;
            end
          end else begin
            if (kindQ == LEN_STRIP_SINGLE) stripHit = termWord && (idxQ >= CW'(3));
            else stripHit = termWord && (idxQ >= CW'(4)) && !idxQ[0];
            if (stripHit) begin
              strobe.emitPkt = 1'b1;
              stateD = ST_IDLE;
            end else if (idxQ == CW'(DEPTH - 1)) begin
              strobe.dropPkt = 1'b1;
              stateD = ST_DISCARD;
            end
          end
        end
      end
      ST_DISCARD: begin
        if (inFire) begin
          idxD = idxQ + CW'(1);
          if (termWord && (kindQ == LEN_STRIP_SINGLE || !idxQ[0])) stateD = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
      lastQ  <= '0;
      kindQ  <= LEN_FIXED;
      opQ    <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
      lastQ  <= lastD;
      kindQ  <= kindD;
      opQ    <= opD;
    end
  end

endmodule

// File: rtl/framer_dp.sv
module framer_dp
  import framer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW = 5,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  logic [31:0]   wordIn,
  input  logic [LW-1:0] emitLen,
  input  logic [7:0]    emitOp,
  input  logic [AW-1:0] rdAddr,
  input  logic [2:0]    envSel,
  output logic          pktValid,
  output logic [7:0]    pktOpcode,
  output logic [LW-1:0] pktLen,
  output logic [AW-1:0] pktStart,
  output logic          pktDrop,
  output logic [31:0]   rdData,
  output logic [31:0]   envData,
  output logic [12:0]   statusLow
);

  logic [31:0]   bufMem [DEPTH];
  logic [AW-1:0] wrPtrQ, startPtrQ, emitStart;
  logic [31:0]   envBank [ENV_COUNT];

  always_ff @(posedge clk) begin
    if (strobe.storeWord) bufMem[wrPtrQ] <= wordIn;
  end

  assign emitStart = strobe.markStart ? wrPtrQ : startPtrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtrQ    <= '0;
      startPtrQ <= '0;
      pktValid  <= 1'b0;
      pktOpcode <= '0;
      pktLen    <= '0;
      pktStart  <= '0;
      pktDrop   <= 1'b0;
    end else begin
      if (strobe.storeWord)
        wrPtrQ <= (wrPtrQ == AW'(DEPTH - 1)) ? '0 : wrPtrQ + AW'(1);
      if (strobe.markStart) startPtrQ <= wrPtrQ;
      pktValid <= strobe.emitPkt;
      pktDrop  <= strobe.dropPkt;
      if (strobe.emitPkt) begin
        pktOpcode <= emitOp;
        pktLen    <= emitLen;
        pktStart  <= emitStart;
      end
    end
  end

  for (genvar g = 0; g < ENV_COUNT; g++) begin : gEnv
    logic [31:0] envQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) envQ <= {8'(8'hE0 + g), 24'h0};
      else if (strobe.envWrite && wordIn[26:24] == 3'(g)) envQ <= wordIn;
    end
    assign envBank[g] = envQ;
  end

  assign rdData    = bufMem[rdAddr];
  assign envData   = envBank[envSel];
  assign statusLow = {envBank[6][1:0], envBank[1][10:0]};

endmodule

// File: rtl/packet_framer.sv
module packet_framer
  import framer_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [31:0]   wordIn,
  input  logic          wordValid,
  output logic          wordReady,
  output logic          pktValid,
  output logic [7:0]    pktOpcode,
  output logic [LW-1:0] pktLen,
  output logic [AW-1:0] pktStart,
  output logic          pktDrop,
  input  logic [AW-1:0] rdAddr,
  output logic [31:0]   rdData,
  input  logic [2:0]    envSel,
  output logic [31:0]   envData,
  output logic [12:0]   statusLow
);

  ctrlStrobe_t   strobe;
  logic [LW-1:0] emitLen;
  logic [7:0]    emitOp;
  logic          readyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) readyQ <= 1'b0;
    else readyQ <= 1'b1;
  end

  assign wordReady = readyQ;

  framer_ctrl #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) uCtrl (
    .clk(clk), .rstN(rstN), .inFire(wordValid && readyQ), .wordIn(wordIn),
    .strobe(strobe), .emitLen(emitLen), .emitOp(emitOp)
  );

  framer_dp #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(wordIn),
    .emitLen(emitLen), .emitOp(emitOp), .rdAddr(rdAddr), .envSel(envSel),
    .pktValid(pktValid), .pktOpcode(pktOpcode), .pktLen(pktLen),
    .pktStart(pktStart), .pktDrop(pktDrop), .rdData(rdData),
    .envData(envData), .statusLow(statusLow)
  );

endmodule

// File: rtl/framer_checks.sv
module framer_checks #(
  parameter int DEPTH = 32,
  parameter int LW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          pktValid,
  input logic [7:0]    pktOpcode,
  input logic [LW-1:0] pktLen,
  input logic          pktDrop,
  input logic [2:0]    envSel,
  input logic [31:0]   envData,
  input logic [12:0]   statusLow
);

  assert_len_range_R11: assert property (@(posedge clk) disable iff (!rstN)
    pktValid |-> (pktLen >= LW'(1) && pktLen <= LW'(DEPTH)));

  assert_vram_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktOpcode >= 8'h80 && pktOpcode <= 8'hDF)
      |-> (pktLen == ((pktOpcode < 8'hA0) ? LW'(4) : LW'(3))));

  assert_strip_single_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktOpcode[7:3] == 5'b01001) |-> pktLen >= LW'(4));

  assert_strip_pair_odd_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktOpcode[7:3] == 5'b01011) |-> (pktLen >= LW'(5) && pktLen[0]));

  assert_env_single_word_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && pktOpcode[7:3] == 5'b11100) |-> pktLen == LW'(1));

  assert_status_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    (envSel == 3'd1) |-> statusLow[10:0] == envData[10:0]);

  assert_status_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    (envSel == 3'd6) |-> statusLow[12:11] == envData[1:0]);

  assert_drop_exclusive_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(pktValid && pktDrop));

endmodule

bind packet_framer framer_checks #(.DEPTH(DEPTH), .LW(LW)) uChecks (
  .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktOpcode(pktOpcode),
  .pktLen(pktLen), .pktDrop(pktDrop), .envSel(envSel), .envData(envData),
  .statusLow(statusLow)
);

// File: tb/packet_framer_test.sv
`timescale 1ns/100ps
module packet_framer_test;

  localparam int TB_DEPTH = 16;
  localparam logic [31:0] TERM_W = 32'h5123_5456;
  localparam logic [31:0] PLAIN_W = 32'h4123_5456;

  typedef struct packed {
    logic              isDrop;
    logic [7:0]        op;
    logic [4:0]        len;
    logic [3:0]        start;
    logic [7:0]        tag;
    logic [15:0][31:0] words;
  } expPkt_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic [31:0] wordIn = '0;
  logic wordValid = 1'b0, wordReady;
  logic pktValid, pktDrop;
  logic [7:0] pktOpcode;
  logic [4:0] pktLen;
  logic [3:0] pktStart, rdAddr = '0;
  logic [31:0] rdData, envData;
  logic [2:0] envSel = '0;
  logic [12:0] statusLow;

  int checks = 0, failures = 0;
  bit finished = 0;
  expPkt_t expQ[$];
  logic [3:0] storePtr = '0;
  logic [15:0][31:0] pw;

  always #10 clk = ~clk;

  packet_framer #(.DEPTH(TB_DEPTH)) uut (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .wordReady(wordReady), .pktValid(pktValid), .pktOpcode(pktOpcode),
    .pktLen(pktLen), .pktStart(pktStart), .pktDrop(pktDrop), .rdAddr(rdAddr),
    .rdData(rdData), .envSel(envSel), .envData(envData), .statusLow(statusLow)
  );

  task automatic chk(input bit ok, input int tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // R2 model: extra words for fixed opcodes, grouped independently of the RTL
  function automatic int tbExtra(input logic [7:0] op);
    if (op == 8'h02) return 2;
    if (op >= 8'h3C && op <= 8'h3F) return 11;
    if ((op >= 8'h2C && op <= 8'h2F) || (op >= 8'h34 && op <= 8'h37)) return 8;
    if (op >= 8'h38 && op <= 8'h3B) return 7;
    if (op >= 8'h24 && op <= 8'h27) return 6;
    if (op >= 8'h30 && op <= 8'h33) return 5;
    if (op >= 8'h28 && op <= 8'h2B) return 4;
    if ((op >= 8'h20 && op <= 8'h23) || (op >= 8'h50 && op <= 8'h57) ||
        (op >= 8'h64 && op <= 8'h67)) return 3;
    if ((op >= 8'h40 && op <= 8'h47) || (op >= 8'h60 && op <= 8'h63) ||
        (op >= 8'h74 && op <= 8'h77) || (op >= 8'h7C && op <= 8'h7F)) return 2;
    if ((op >= 8'h68 && op <= 8'h6B) || (op >= 8'h70 && op <= 8'h73) ||
        (op >= 8'h78 && op <= 8'h7B)) return 1;
    if (op >= 8'h80 && op <= 8'h9F) return 3;  // R3
    if (op >= 8'hA0 && op <= 8'hDF) return 2;  // R3
    return 0;
  endfunction

  task automatic sendWord(input logic [31:0] w);
    wordIn = w;
    wordValid = 1'b1;
    do @(posedge clk); while (!wordReady);
    @(negedge clk);
    wordValid = 1'b0;
  endtask

  task automatic runPacket(input int n, input int tag, input int gapAfter, input int gapLen);
    expPkt_t e;
    e.isDrop = 1'b0;
    e.op = pw[0][31:24];
    e.len = 5'(n);
    e.start = storePtr;
    e.tag = 8'(tag);
    e.words = pw;
    expQ.push_back(e);
    for (int i = 0; i < n; i++) begin
      sendWord(pw[i]);
      if (i == gapAfter) begin
        for (int g = 0; g < gapLen; g++) begin
          chk(!pktValid, 6, "strobe during pause", 32'(pktValid), 32'd0);  // R6
          @(negedge clk);
        end
      end
    end
    storePtr = storePtr + 4'(n);
  endtask

  task automatic runDrop(input int tag);
    expPkt_t e;
    e = '0;
    e.isDrop = 1'b1;
    e.tag = 8'(tag);
    expQ.push_back(e);
    for (int i = 0; i < TB_DEPTH; i++) sendWord(pw[i]);
    storePtr = storePtr + 4'(TB_DEPTH);
  endtask

  // Scoreboard monitor: R7 start index and buffer contents, R11 strobe timing
  always @(negedge clk) begin
    if (rstN && (pktValid || pktDrop)) begin
      if (expQ.size() == 0) begin
        chk(0, 11, "unexpected strobe", {30'd0, pktDrop, pktValid}, 32'd0);
      end else begin
        expPkt_t e;
        e = expQ.pop_front();
        if (e.isDrop) begin
          chk(pktDrop && !pktValid, int'(e.tag), "drop strobe",
              {30'd0, pktDrop, pktValid}, 32'd2);
        end else begin
          chk(pktValid && !pktDrop, 11, "packet strobe", {30'd0, pktDrop, pktValid}, 32'd1);
          chk(pktOpcode == e.op, int'(e.tag), "opcode", 32'(pktOpcode), 32'(e.op));
          chk(pktLen == e.len, int'(e.tag), "length", 32'(pktLen), 32'(e.len));
          chk(pktStart == e.start, 7, "start index", 32'(pktStart), 32'(e.start));
          for (int i = 0; i < int'(e.len); i++) begin
            rdAddr = e.start + 4'(i);
            #0.5;
            chk(rdData == e.words[i], 7, "buffered word", rdData, e.words[i]);
          end
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", expQ.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] fixedOps[19] = '{8'h02, 8'h20, 8'h24, 8'h2C, 8'h34, 8'h3C, 8'h44,
                                 8'h52, 8'h60, 8'h66, 8'h6A, 8'h6D, 8'h70, 8'h75,
                                 8'h79, 8'h7E, 8'h00, 8'h1F, 8'hF3};
    logic [7:0] vramOps[5] = '{8'h80, 8'h9F, 8'hA0, 8'hC5, 8'hDF};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(wordReady, 1, "ready", 32'(wordReady), 32'd1);
    chk(!pktValid && !pktDrop, 1, "strobes idle", {30'd0, pktDrop, pktValid}, 32'd0);
    chk(statusLow == 13'd0, 1, "status", 32'(statusLow), 32'd0);
    for (int i = 0; i < 8; i++) begin
      envSel = 3'(i);
      #1;
      chk(envData == {8'(8'hE0 + i), 24'h0}, 1, "env reset", envData, {8'(8'hE0 + i), 24'h0});
    end
    @(negedge clk);

    // R2: fixed lengths, terminator-like words inside do not shorten them
    foreach (fixedOps[k]) begin
      pw = '0;
      pw[0] = {fixedOps[k], 24'h00_1234};
      for (int i = 1; i < 16; i++) pw[i] = (i == 1) ? TERM_W : 32'h0101_0101 * i;
      runPacket(tbExtra(fixedOps[k]) + 1, 2, -1, 0);
    end

    // R3: VRAM copy / transfer headers
    foreach (vramOps[k]) begin
      pw = '0;
      pw[0] = {vramOps[k], 24'h0};
      for (int i = 1; i < 4; i++) pw[i] = 32'h0010_0020 * i;
      runPacket(tbExtra(vramOps[k]) + 1, 3, -1, 0);
    end

    // R4: single-step strip, terminators at index 1 and 2 are ignored
    pw = '0;
    pw[0] = 32'h4A33_4455; pw[1] = TERM_W; pw[2] = TERM_W; pw[3] = PLAIN_W; pw[4] = TERM_W;
    runPacket(5, 4, -1, 0);
    pw = '0;
    pw[0] = 32'h4800_0001; pw[1] = PLAIN_W; pw[2] = PLAIN_W; pw[3] = 32'h5FFF_5000;
    runPacket(4, 4, -1, 0);

    // R5: pair-step strip, odd index terminator ignored
    pw = '0;
    pw[0] = 32'h5C00_0077; pw[1] = TERM_W; pw[2] = TERM_W; pw[3] = TERM_W;
    pw[4] = PLAIN_W; pw[5] = TERM_W; pw[6] = TERM_W;
    runPacket(7, 5, -1, 0);

    // R6: incomplete packet held across an input pause
    pw = '0;
    pw[0] = 32'h3800_0000;
    for (int i = 1; i < 8; i++) pw[i] = 32'hA5A5_0000 + i;
    runPacket(8, 6, 2, 5);

    // R8 / R9: environment writes and status field
    pw = '0; pw[0] = 32'hE1AB_C5A5;
    runPacket(1, 8, -1, 0);
    envSel = 3'd1; #1;
    chk(envData == 32'hE1AB_C5A5, 8, "env1 value", envData, 32'hE1AB_C5A5);
    chk(statusLow[10:0] == 11'h5A5, 9, "status low bits", 32'(statusLow), 32'h5A5);
    @(negedge clk);
    pw = '0; pw[0] = 32'hE600_0002;
    runPacket(1, 8, -1, 0);
    envSel = 3'd6; #1;
    chk(envData == 32'hE600_0002, 8, "env6 value", envData, 32'hE600_0002);
    chk(statusLow == 13'h15A5, 9, "status full", 32'(statusLow), 32'h15A5);
    envSel = 3'd0; #1;
    chk(envData == 32'hE000_0000, 8, "env0 untouched", envData, 32'hE000_0000);
    @(negedge clk);

    // R10: single-step strip overflow, then discard until terminator
    pw = '0;
    pw[0] = 32'h4900_0000;
    for (int i = 1; i < 16; i++) pw[i] = PLAIN_W + i;
    runDrop(10);
    sendWord(PLAIN_W);
    sendWord(TERM_W);
    pw = '0; pw[0] = 32'h2000_0001; pw[1] = 32'h11; pw[2] = 32'h22; pw[3] = 32'h33;
    runPacket(4, 10, -1, 0);

    // R10: pair-step overflow, odd-index terminator does not end the discard
    pw = '0;
    pw[0] = 32'h5800_0000;
    for (int i = 1; i < 16; i++) pw[i] = PLAIN_W + i;
    runDrop(10);
    sendWord(PLAIN_W);
    sendWord(TERM_W);
    sendWord(TERM_W);
    pw = '0; pw[0] = 32'h6000_0005; pw[1] = 32'h44; pw[2] = 32'h55;
    runPacket(3, 10, -1, 0);

    // R7 / R11: back-to-back single-word packets across the index wrap
    for (int i = 0; i < 20; i++) begin
      pw = '0;
      pw[0] = {(i % 2 == 0) ? 8'h00 : 8'hE3, 24'(i * 7)};
      runPacket(1, 7, -1, 0);
    end

    repeat (4) @(negedge clk);
    chk(expQ.size() == 0, 11, "missing strobes", 32'(expQ.size()), 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule